// File: doc/BRIEF.md
# DMA List Walker with Stall-and-Notify

This block runs a list-form DMA command. A list sits in local store as a run of 8-byte elements. The walker fetches the elements one at a time. For each legal element it hands one elementary transfer request to a downstream transfer engine and waits for that request to finish. It then moves the local-store address forward for the next element. The data movement itself belongs to the engine.

An element can carry a stall-and-notify flag. The flagged element is still transferred. After it, the walker stores its resume point for the command's tag (next list address, elements left, local address, upper address half). It sets the tag's bit in a stall status register and returns to idle, where it can serve other commands. An acknowledge carrying that tag picks the stored point back up and continues the walk from the next element. A command ends with a one-cycle completion pulse and a status code:

- 0 for success
- 1 when the transfer engine reported an error
- 2 when an element had an illegal size

Top module: `dma_list_walker`

## Requirements
- R1: Each element is a 64-bit word read from `ls_rd_data`. Bit 63 is the stall flag, bits 47:32 are the transfer size, and bits 31:0 are the low external address. The request's `xfer_ea` is `{cmd_ea_hi, bits 31:0}` and `xfer_tag` is the command tag.
- R2: The element count is `cmd_list_bytes / 8`, rounded down. Elements are fetched from consecutive 8-byte addresses starting at `cmd_list_addr`, which is an 18-bit local-store address. A count of zero completes at once with status 0 and issues no transfer.
- R3: The local base is `cmd_lsa` with its low 4 bits cleared. Each element's `xfer_lsa` is the base ORed with bits 3:0 of that element's external address. After each element the base grows by the larger of the element size and 16.
- R4: Sizes 1, 2, 4 and 8, and every size of 16 or more, are legal. Any other size, 0 included, ends the command with status 2, and that element is not transferred.
- R5: An engine error (`xfer_err` with `xfer_done`) ends the command with status 1, and no later element is fetched.
- R6: When all elements transfer without error, the command ends with status 0. `cmd_done` is a pulse exactly one cycle long.
- R7: `xfer_req` stays high, with ea, lsa, size and tag unchanged, until the cycle in which `xfer_done` is high.
- R8: A flagged element is transferred first. The walker then sets bit `tag` of the stall status and becomes ready for a new command without pulsing `cmd_done`.
- R9: `stall_rd_ready` is high while any stall bit is set. `stall_rd_data` shows the accumulated bits, and a read (`stall_rd_en` while ready) clears them.
- R10: An acknowledge with a tag of 32 or more, or with a tag that has no stored point, gives a one-cycle `ack_err` pulse and starts no transfer.
- R11: A valid acknowledge consumes the stored point and continues from the next element, using the stored local address, upper address half and tag. A second acknowledge of the same tag is then an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Walker idle and no acknowledge pending; the command is taken |
| cmd_list_addr | input | 18 | Local-store byte address of the list |
| cmd_list_bytes | input | 16 | List length in bytes |
| cmd_lsa | input | 18 | Starting local-store address for the data |
| cmd_tag | input | 5 | Command tag |
| cmd_ea_hi | input | 32 | Upper half of the external address |
| ls_rd_en | output | 1 | Local-store read strobe |
| ls_rd_addr | output | 18 | Local-store read byte address |
| ls_rd_data | input | 64 | Read data, valid the cycle after the strobe |
| xfer_req | output | 1 | Elementary transfer request |
| xfer_ea | output | 64 | External address of the transfer |
| xfer_lsa | output | 18 | Local address of the transfer |
| xfer_size | output | 16 | Transfer size in bytes |
| xfer_tag | output | 5 | Tag of the transfer |
| xfer_done | input | 1 | Transfer finished |
| xfer_err | input | 1 | Transfer failed; sampled with `xfer_done` |
| cmd_done | output | 1 | Command completed (pulse) |
| cmd_status | output | 2 | Completion code: 0 ok, 1 transfer error, 2 size error |
| stall_rd_en | input | 1 | Read and clear the stall status |
| stall_rd_ready | output | 1 | At least one stall bit set |
| stall_rd_data | output | 32 | Accumulated stall bits, one per tag |
| ack_valid | input | 1 | Stall acknowledge, taken while the walker is idle |
| ack_tag | input | 8 | Tag being acknowledged |
| ack_err | output | 1 | Acknowledge rejected (pulse) |

## Verification
The assertions rely on three things about the inputs:

- The list address of every command is a multiple of 8, so the fetch-alignment property depends on it.
- The engine raises `xfer_done` only while a request is open.
- An acknowledge is offered only while the walker is idle.

The bench keeps to all three. It places every list on an 8-byte boundary. Its engine model answers only an open request, after a fixed latency. It sends commands and acknowledges only after the previous command has finished or stalled.

// File: rtl/dlw_pkg.sv
// Shared constants and types of the DMA list walker.
// Assumes an 18-bit local store and a 16-bit list length.
package dlw_pkg;
    localparam int LS_AW   = 18;
    localparam int BYTES_W = 16;
    localparam int CNT_W   = BYTES_W - 3;
    localparam int SIZE_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_LATCH = 2'd2,
        ST_XFER  = 2'd3
    } walk_state_t;

    localparam logic [1:0] STAT_OK       = 2'd0;
    localparam logic [1:0] STAT_SEQ_ERR  = 2'd1;
    localparam logic [1:0] STAT_SIZE_ERR = 2'd2;

    typedef struct packed {
        logic [LS_AW-1:0] list_addr;
        logic [CNT_W-1:0] left;
        logic [LS_AW-1:0] base;
        logic [31:0]      ea_hi;
    } resume_t;
endpackage

// File: rtl/dlw_elem_check.sv
// Decodes one list element: stall flag, size legality, local address
// and base step. Purely combinational; assumes a valid element word.
module dlw_elem_check
    import dlw_pkg::*;
(
    input  logic [63:0]       elem,
    input  logic [LS_AW-1:0]  base,
    output logic              legal,
    output logic              stall,
    output logic [SIZE_W-1:0] size,
    output logic [LS_AW-1:0]  lsa,
    output logic [LS_AW-1:0]  step
);
    logic [14:0] unused_flag_bits;

    assign unused_flag_bits = elem[62:48];
    assign stall = elem[63];
    assign size  = elem[47:32];

    // Legal sizes: 1, 2, 4, 8 or anything from 16 up.
    always_comb legal = (size == 16'd1) || (size == 16'd2) || (size == 16'd4)
                     || (size == 16'd8) || (size >= 16'd16);

    // Local address keeps the external address's low nibble.
    always_comb lsa = base | {{(LS_AW-4){1'b0}}, elem[3:0]};

    // Base advance is at least one 16-byte line.
    always_comb step = (size < 16'd16) ? LS_AW'(16) : LS_AW'(size);
endmodule

// File: rtl/dlw_resume_table.sv
// Per-tag store of paused walk state with a valid bit per entry.
// Assumes save and take never target the same cycle.
module dlw_resume_table
    import dlw_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    localparam int TAG_W = $clog2(NUM_TAGS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_en,
    input  logic [TAG_W-1:0] save_tag,
    input  resume_t          save_data,
    input  logic             take_en,
    input  logic [TAG_W-1:0] take_tag,
    output logic             hit,
    output resume_t          rd_data
);
    resume_t            entries [NUM_TAGS];
    logic [NUM_TAGS-1:0] valid;

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_entry
        resume_t ent_q;
        logic    vld_q;
        // Hold one tag's paused state until it is acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                ent_q <= '0;
            end else if (save_en && save_tag == TAG_W'(t)) begin
                vld_q <= 1'b1;
                ent_q <= save_data;
            end else if (take_en && take_tag == TAG_W'(t)) begin
                vld_q <= 1'b0;
            end
        end
        assign entries[t] = ent_q;
        assign valid[t]   = vld_q;
    end

    assign hit     = valid[take_tag];
    assign rd_data = entries[take_tag];
endmodule

// File: rtl/dlw_stall_status.sv
// Sticky stall bits, one per tag; a read returns and clears them.
// A bit set in the same cycle as a read survives the read.
module dlw_stall_status #(
    parameter int NUM_TAGS = 32,
    localparam int TAG_W = $clog2(NUM_TAGS)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [TAG_W-1:0]    set_tag,
    input  logic                rd_en,
    output logic                rd_ready,
    output logic [NUM_TAGS-1:0] rd_data
);
    logic [NUM_TAGS-1:0] bits_q;

    // Accumulate stall bits, dropping those handed out by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= '0;
        else
            bits_q <= ((rd_en && rd_ready) ? '0 : bits_q)
                    | (set_en ? (NUM_TAGS'(1) << set_tag) : '0);
    end

    assign rd_ready = |bits_q;
    assign rd_data  = bits_q;
endmodule

// File: rtl/dma_list_walker.sv
// Walks a DMA list in local store, one transfer request per element,
// pausing per tag on a stall flag and resuming on acknowledge.
// Assumes list addresses are 8-byte aligned and read data arrives one
// cycle after ls_rd_en.
module dma_list_walker
    import dlw_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    parameter int ACK_W    = 8,
    localparam int TAG_W   = $clog2(NUM_TAGS)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [LS_AW-1:0]    cmd_list_addr,
    input  logic [BYTES_W-1:0]  cmd_list_bytes,
    input  logic [LS_AW-1:0]    cmd_lsa,
    input  logic [TAG_W-1:0]    cmd_tag,
    input  logic [31:0]         cmd_ea_hi,
    output logic                ls_rd_en,
    output logic [LS_AW-1:0]    ls_rd_addr,
    input  logic [63:0]         ls_rd_data,
    output logic                xfer_req,
    output logic [63:0]         xfer_ea,
    output logic [LS_AW-1:0]    xfer_lsa,
    output logic [SIZE_W-1:0]   xfer_size,
    output logic [TAG_W-1:0]    xfer_tag,
    input  logic                xfer_done,
    input  logic                xfer_err,
    output logic                cmd_done,
    output logic [1:0]          cmd_status,
    input  logic                stall_rd_en,
    output logic                stall_rd_ready,
    output logic [NUM_TAGS-1:0] stall_rd_data,
    input  logic                ack_valid,
    input  logic [ACK_W-1:0]    ack_tag,
    output logic                ack_err
);
    walk_state_t       state;
    logic [LS_AW-1:0]  cur_addr;
    logic [LS_AW-1:0]  base;
    logic [CNT_W-1:0]  left;
    logic [31:0]       ea_hi;
    logic [TAG_W-1:0]  tag;
    logic              stall_q;
    logic [LS_AW-1:0]  step_q;
    logic [2:0]        unused_len_bits;

    logic              chk_legal, chk_stall;
    logic [SIZE_W-1:0] chk_size;
    logic [LS_AW-1:0]  chk_lsa, chk_step;
    logic              idle, ack_in_range, tbl_hit, take_en, pause_now;
    resume_t           tbl_rd, save_data;

    assign unused_len_bits = cmd_list_bytes[2:0];
    assign idle       = (state == ST_IDLE);
    assign cmd_ready  = idle && !ack_valid;
    assign ls_rd_en   = (state == ST_READ);
    assign ls_rd_addr = cur_addr;
    assign xfer_req   = (state == ST_XFER);
    assign xfer_tag   = tag;

    assign ack_in_range = (ack_tag < ACK_W'(NUM_TAGS));
    assign take_en      = idle && ack_valid && ack_in_range && tbl_hit;
    assign pause_now    = xfer_req && xfer_done && !xfer_err && stall_q;
    assign save_data    = '{list_addr: cur_addr + LS_AW'(8), left: left - CNT_W'(1),
                            base: base + step_q, ea_hi: ea_hi};

    dlw_elem_check u_check (
        .elem  (ls_rd_data),
        .base  (base),
        .legal (chk_legal),
        .stall (chk_stall),
        .size  (chk_size),
        .lsa   (chk_lsa),
        .step  (chk_step)
    );

    dlw_resume_table #(.NUM_TAGS(NUM_TAGS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_en   (pause_now),
        .save_tag  (tag),
        .save_data (save_data),
        .take_en   (take_en),
        .take_tag  (ack_tag[TAG_W-1:0]),
        .hit       (tbl_hit),
        .rd_data   (tbl_rd)
    );

    dlw_stall_status #(.NUM_TAGS(NUM_TAGS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (pause_now),
        .set_tag  (tag),
        .rd_en    (stall_rd_en),
        .rd_ready (stall_rd_ready),
        .rd_data  (stall_rd_data)
    );

    // Walk sequencer: start or resume, fetch, check, transfer, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            base       <= '0;
            left       <= '0;
            ea_hi      <= '0;
            tag        <= '0;
            stall_q    <= 1'b0;
            step_q     <= '0;
            xfer_ea    <= '0;
            xfer_lsa   <= '0;
            xfer_size  <= '0;
            cmd_done   <= 1'b0;
            cmd_status <= STAT_OK;
            ack_err    <= 1'b0;
        end else begin
            cmd_done <= 1'b0;
            ack_err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ack_valid) begin
                        if (!take_en) begin
                            ack_err <= 1'b1;
                        end else begin
                            cur_addr <= tbl_rd.list_addr;
                            left     <= tbl_rd.left;
                            base     <= tbl_rd.base;
                            ea_hi    <= tbl_rd.ea_hi;
                            tag      <= ack_tag[TAG_W-1:0];
                            if (tbl_rd.left == '0) begin
                                cmd_done   <= 1'b1;
                                cmd_status <= STAT_OK;
                            end else begin
                                state <= ST_READ;
                            end
                        end
                    end else if (cmd_valid) begin
                        cur_addr <= cmd_list_addr;
                        left     <= cmd_list_bytes[BYTES_W-1:3];
                        base     <= {cmd_lsa[LS_AW-1:4], 4'b0000};
                        ea_hi    <= cmd_ea_hi;
                        tag      <= cmd_tag;
                        if (cmd_list_bytes[BYTES_W-1:3] == '0) begin
                            cmd_done   <= 1'b1;
                            cmd_status <= STAT_OK;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ: state <= ST_LATCH;
                ST_LATCH: begin
                    if (!chk_legal) begin
                        cmd_done   <= 1'b1;
                        cmd_status <= STAT_SIZE_ERR;
                        state      <= ST_IDLE;
                    end else begin
                        xfer_ea   <= {ea_hi, ls_rd_data[31:0]};
                        xfer_lsa  <= chk_lsa;
                        xfer_size <= chk_size;
                        stall_q   <= chk_stall;
                        step_q    <= chk_step;
                        state     <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (xfer_done) begin
                        if (xfer_err) begin
                            cmd_done   <= 1'b1;
                            cmd_status <= STAT_SEQ_ERR;
                            state      <= ST_IDLE;
                        end else begin
                            cur_addr <= cur_addr + LS_AW'(8);
                            base     <= base + step_q;
                            left     <= left - CNT_W'(1);
                            if (stall_q) begin
                                state <= ST_IDLE;
                            end else if (left == CNT_W'(1)) begin
                                cmd_done   <= 1'b1;
                                cmd_status <= STAT_OK;
                                state      <= ST_IDLE;
                            end else begin
                                state <= ST_READ;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dlw_checker.sv
// Protocol properties of the DMA list walker, bound to its top module.
// Assumes 8-byte aligned list addresses from the command source.
module dlw_checker #(
    parameter int NUM_TAGS = 32,
    parameter int LS_AW    = 18,
    localparam int TAG_W   = $clog2(NUM_TAGS)
)(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             ls_rd_en,
    input logic [LS_AW-1:0] ls_rd_addr,
    input logic             xfer_req,
    input logic [63:0]      xfer_ea,
    input logic [LS_AW-1:0] xfer_lsa,
    input logic [15:0]      xfer_size,
    input logic [TAG_W-1:0] xfer_tag,
    input logic             xfer_done,
    input logic             cmd_done,
    input logic             ack_valid,
    input logic             ack_err
);
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done |=> xfer_req);

    assert_fields_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done |=> $stable(xfer_ea) && $stable(xfer_lsa)
                                   && $stable(xfer_size) && $stable(xfer_tag));

    assert_legal_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (xfer_size == 16'd1 || xfer_size == 16'd2 || xfer_size == 16'd4
                      || xfer_size == 16'd8 || xfer_size >= 16'd16));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    assert_fetch_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ls_rd_en |-> ls_rd_addr[2:0] == 3'b000);

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !xfer_req && !ls_rd_en);

    assert_ack_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> $past(ack_valid));
endmodule

bind dma_list_walker dlw_checker #(.NUM_TAGS(NUM_TAGS), .LS_AW(dlw_pkg::LS_AW)) u_dlw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .ls_rd_en   (ls_rd_en),
    .ls_rd_addr (ls_rd_addr),
    .xfer_req   (xfer_req),
    .xfer_ea    (xfer_ea),
    .xfer_lsa   (xfer_lsa),
    .xfer_size  (xfer_size),
    .xfer_tag   (xfer_tag),
    .xfer_done  (xfer_done),
    .cmd_done   (cmd_done),
    .ack_valid  (ack_valid),
    .ack_err    (ack_err)
);

// File: tb/dma_list_walker_bench.sv
// Scoreboard bench: tests push expected transfers, a monitor compares.
module dma_list_walker_bench;
    localparam logic [31:0] ERR_EA = 32'hDEAD_0000;

    typedef struct packed {
        logic [63:0] ea;
        logic [17:0] lsa;
        logic [15:0] size;
        logic [4:0]  tag;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic [17:0] cmd_list_addr = '0;
    logic [15:0] cmd_list_bytes = '0;
    logic [17:0] cmd_lsa = '0;
    logic [4:0]  cmd_tag = '0;
    logic [31:0] cmd_ea_hi = '0;
    logic        ls_rd_en;
    logic [17:0] ls_rd_addr;
    logic [63:0] ls_rd_data = '0;
    logic        xfer_req;
    logic [63:0] xfer_ea;
    logic [17:0] xfer_lsa;
    logic [15:0] xfer_size;
    logic [4:0]  xfer_tag;
    logic        xfer_done = 1'b0, xfer_err = 1'b0;
    logic        cmd_done;
    logic [1:0]  cmd_status;
    logic        stall_rd_en = 1'b0, stall_rd_ready;
    logic [31:0] stall_rd_data;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_tag = '0;
    logic        ack_err;

    logic [63:0] ls_mem [64];
    logic [1:0]  eng_cnt = '0;
    xfer_t       exp_q [$];
    int          checks = 0, fails = 0;
    int          done_cnt = 0, ack_err_cnt = 0, xfer_cnt = 0;
    logic [1:0]  last_status = '0;
    xfer_t       held;
    logic        held_vld = 1'b0;

    always #4 clk = ~clk;

    dma_list_walker u_dma_list_walker (.*);

    // Local-store model: one-cycle read latency.
    always @(posedge clk) if (ls_rd_en) ls_rd_data <= ls_mem[ls_rd_addr[8:3]];

    // Transfer engine model: answers an open request after three cycles.
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (xfer_req && !xfer_done) begin
            if (eng_cnt == 2'd2) begin
                xfer_done <= 1'b1;
                xfer_err  <= (xfer_ea[31:0] == ERR_EA);
                eng_cnt   <= '0;
            end else begin
                eng_cnt <= eng_cnt + 2'd1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard compare, stability of open requests, pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            xfer_t cur;
            cur = '{xfer_ea, xfer_lsa, xfer_size, xfer_tag};
            if (xfer_req && held_vld)
                check(cur == held, "R7", "request held stable", 64'(cur), 64'(held));
            held     = cur;
            held_vld = xfer_req && !xfer_done;
            if (xfer_req && xfer_done) begin
                xfer_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected transfer", xfer_ea, 64'h0);
                end else begin
                    xfer_t e;
                    e = exp_q.pop_front();
                    check(cur.ea == e.ea, "R1", "xfer ea", cur.ea, e.ea);
                    check(cur.lsa == e.lsa, "R3", "xfer lsa", 64'(cur.lsa), 64'(e.lsa));
                    check(cur.size == e.size, "R1", "xfer size", 64'(cur.size), 64'(e.size));
                    check(cur.tag == e.tag, "R1", "xfer tag", 64'(cur.tag), 64'(e.tag));
                end
            end
            if (cmd_done) begin
                done_cnt++;
                last_status = cmd_status;
            end
            if (ack_err) ack_err_cnt++;
        end
    end

    function automatic logic [63:0] el(input bit stall, input logic [15:0] sz,
                                       input logic [31:0] lo);
        return {stall ? 16'h8000 : 16'h0000, sz, lo};
    endfunction

    task automatic expect_x(input logic [31:0] hi, input logic [31:0] lo,
                            input logic [17:0] lsa, input logic [15:0] sz, input logic [4:0] tg);
        exp_q.push_back('{{hi, lo}, lsa, sz, tg});
    endtask

    task automatic send_cmd(input logic [17:0] la, input logic [15:0] nb,
                            input logic [17:0] lsa, input logic [4:0] tg, input logic [31:0] hi);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_list_addr = la; cmd_list_bytes = nb;
        cmd_lsa = lsa; cmd_tag = tg; cmd_ea_hi = hi;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_ack(input logic [7:0] tg);
        @(negedge clk);
        ack_valid = 1'b1; ack_tag = tg;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic wait_done(input logic [1:0] exp_st, input string req);
        int start;
        start = done_cnt;
        for (int i = 0; i < 400 && done_cnt == start; i++) @(negedge clk);
        check(done_cnt == start + 1, req, "completion seen", 64'(done_cnt - start), 64'd1);
        check(last_status == exp_st, req, "status", 64'(last_status), 64'(exp_st));
        check(exp_q.size() == 0, req, "all transfers issued", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic wait_quiet(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ls_mem[i] = '0;
        ls_mem[0]  = el(0, 16, 32'h1000_0005);
        ls_mem[1]  = el(0, 4,  32'h1000_0103);
        ls_mem[2]  = el(0, 32, 32'h2000_0000);
        ls_mem[8]  = el(0, 1,  32'h0000_0300);
        ls_mem[9]  = el(0, 2,  32'h0000_0301);
        ls_mem[10] = el(0, 8,  32'h0000_0302);
        ls_mem[11] = el(0, 3,  32'h0000_0303);
        ls_mem[12] = el(0, 0,  32'h0000_0000);
        ls_mem[13] = el(0, 15, 32'h0000_0000);
        ls_mem[14] = el(0, 16, ERR_EA);
        ls_mem[15] = el(0, 16, 32'h0000_0000);
        ls_mem[16] = el(0, 64, 32'h4444_0008);
        ls_mem[20] = el(0, 16, 32'h0000_0500);
        ls_mem[21] = el(1, 20, 32'h0000_0511);
        ls_mem[22] = el(0, 16, 32'h0000_0522);
        ls_mem[24] = el(0, 16, 32'h0000_0600);
        ls_mem[28] = el(1, 16, 32'h0000_0700);
        ls_mem[29] = el(1, 16, 32'h0000_0800);
    end

    initial begin
        int d0, a0, x0;
        repeat (3) @(negedge clk);
        check(cmd_ready && !xfer_req && !cmd_done && !stall_rd_ready, "R6", "reset state",
              64'({cmd_ready, xfer_req, cmd_done, stall_rd_ready}), 64'b1000);
        rst_n = 1'b1;

        // R1 R3 R6: three elements, low nibbles carried into lsa
        expect_x(32'hA, 32'h1000_0005, 18'h01235, 16, 3);
        expect_x(32'hA, 32'h1000_0103, 18'h01243, 4, 3);
        expect_x(32'hA, 32'h2000_0000, 18'h01250, 32, 3);
        send_cmd(18'h0, 16'd24, 18'h01234, 5'd3, 32'hA);
        wait_done(2'd0, "R6");

        // R4: sizes 1, 2, 8 pass, size 3 aborts
        expect_x(0, 32'h300, 18'h00000, 1, 1);
        expect_x(0, 32'h301, 18'h00011, 2, 1);
        expect_x(0, 32'h302, 18'h00022, 8, 1);
        send_cmd(18'h40, 16'd32, 18'h0000F, 5'd1, 0);
        wait_done(2'd2, "R4");
        // R4: size 0 and size 15 rejected without transfer
        send_cmd(18'h60, 16'd8, 18'h0, 5'd1, 0);
        wait_done(2'd2, "R4");
        send_cmd(18'h68, 16'd8, 18'h0, 5'd1, 0);
        wait_done(2'd2, "R4");

        // R5: engine error stops the walk
        expect_x(32'h1, ERR_EA, 18'h00000, 16, 4);
        send_cmd(18'h70, 16'd16, 18'h0, 5'd4, 32'h1);
        wait_done(2'd1, "R5");

        // R2: empty list completes at once; 12 bytes means one element
        send_cmd(18'h80, 16'd0, 18'h0, 5'd0, 0);
        wait_done(2'd0, "R2");
        expect_x(32'h2, 32'h4444_0008, 18'h00108, 64, 6);
        send_cmd(18'h80, 16'd12, 18'h00100, 5'd6, 32'h2);
        wait_done(2'd0, "R2");

        // R8: stall after the flagged element, no completion
        d0 = done_cnt;
        expect_x(32'h7, 32'h500, 18'h02000, 16, 5);
        expect_x(32'h7, 32'h511, 18'h02011, 20, 5);
        send_cmd(18'hA0, 16'd24, 18'h02000, 5'd5, 32'h7);
        wait_quiet(40);
        check(exp_q.size() == 0, "R8", "flagged element transferred", 64'(exp_q.size()), 0);
        check(done_cnt == d0, "R8", "no completion on stall", 64'(done_cnt - d0), 0);
        check(cmd_ready, "R8", "ready after stall", 64'(cmd_ready), 1);
        check(stall_rd_ready && stall_rd_data == 32'h20, "R8", "stall bit for tag 5",
              64'(stall_rd_data), 64'h20);

        // R8: another tag runs while tag 5 is paused
        expect_x(0, 32'h600, 18'h00000, 16, 2);
        send_cmd(18'hC0, 16'd8, 18'h0, 5'd2, 0);
        wait_done(2'd0, "R8");

        // R9: read returns and clears
        @(negedge clk);
        check(stall_rd_data == 32'h20, "R9", "read data", 64'(stall_rd_data), 64'h20);
        stall_rd_en = 1'b1;
        @(negedge clk);
        stall_rd_en = 1'b0;
        check(!stall_rd_ready && stall_rd_data == 0, "R9", "cleared after read",
              64'(stall_rd_data), 0);

        // R11: acknowledge resumes with saved local address
        expect_x(32'h7, 32'h522, 18'h02026, 16, 5);
        send_ack(8'd5);
        wait_done(2'd0, "R11");

        // R10 R11: repeat ack, out-of-range tag, unknown tag
        a0 = ack_err_cnt; x0 = xfer_cnt;
        send_ack(8'd5);
        wait_quiet(3);
        check(ack_err_cnt == a0 + 1, "R11", "second ack rejected", 64'(ack_err_cnt - a0), 1);
        send_ack(8'd40);
        wait_quiet(3);
        check(ack_err_cnt == a0 + 2, "R10", "tag 40 rejected", 64'(ack_err_cnt - a0), 2);
        send_ack(8'd7);
        wait_quiet(3);
        check(ack_err_cnt == a0 + 3, "R10", "unsaved tag rejected", 64'(ack_err_cnt - a0), 3);
        check(xfer_cnt == x0, "R10", "no transfer on bad ack", 64'(xfer_cnt - x0), 0);

        // R8 R9: stalls on two tags accumulate
        expect_x(0, 32'h700, 18'h00000, 16, 1);
        send_cmd(18'hE0, 16'd8, 18'h0, 5'd1, 0);
        wait_quiet(20);
        expect_x(0, 32'h800, 18'h00000, 16, 9);
        send_cmd(18'hE8, 16'd8, 18'h0, 5'd9, 0);
        wait_quiet(20);
        check(stall_rd_data == 32'h202, "R9", "two stall bits", 64'(stall_rd_data), 64'h202);
        stall_rd_en = 1'b1;
        @(negedge clk);
        stall_rd_en = 1'b0;

        // R11: resuming a list with nothing left completes at once
        x0 = xfer_cnt;
        send_ack(8'd1);
        wait_done(2'd0, "R11");
        send_ack(8'd9);
        wait_done(2'd0, "R11");
        check(xfer_cnt == x0, "R11", "no transfer on empty resume", 64'(xfer_cnt - x0), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule